// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block brings one gated power domain up or down on request. It owns the domain's control outputs: a five-bit control word, the SRAM power-down field and the bus-protection field. It walks them through a fixed ordered sequence, one change at a time. Between steps it waits on handshakes from the domain:

- two power-good acknowledges, one per power switch stage;
- a vector of SRAM power-down acknowledges.

Each wait is bounded by a cycle-count timeout. Completion is reported through `done`. An expired wait is reported through `err`. The settled domain state is shown on `dom_on`.

A request is a one-cycle pulse on `req_valid`, with `req_on` giving the target state (1 = on, 0 = off). Two parameters describe the domain:

- `SRAM_ACK_MASK` selects which SRAM acknowledge bits are meaningful. When it is zero, both SRAM waits are skipped.
- `BUS_PROT_MASK` is the pattern driven on `bus_prot` while protection is raised. When it is zero, both protection steps are skipped.

`STEP_HOLD` sets how many cycles every action step lasts. `TMO_LIMIT` sets how many cycles a wait may last before the sequence aborts.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset the domain is off, with these output values:
  - `pwr_ctl` = 5'b10010 (bit0 active-low reset, bit1 isolation, bit2 main switch, bit3 secondary switch, bit4 clock disable);
  - `sram_pdn` all ones;
  - `bus_prot` = `BUS_PROT_MASK`;
  - `busy`, `done`, `err` and `dom_on` all 0.
- R2: Power-up makes these changes in order, and ends with `pwr_ctl` = 5'b01101, `sram_pdn` = 0 and `bus_prot` = 0:
  1. main switch set;
  2. secondary switch set;
  3. wait for power good;
  4. clock disable cleared;
  5. isolation cleared;
  6. reset released;
  7. `sram_pdn` cleared;
  8. SRAM acknowledge wait;
  9. `bus_prot` dropped.
- R3: Power-down makes these changes in order, and ends with `pwr_ctl` = 5'b10010:
  1. `bus_prot` raised;
  2. `sram_pdn` set to all ones;
  3. SRAM acknowledge wait;
  4. isolation set;
  5. reset driven low;
  6. clock disable set;
  7. main switch cleared;
  8. secondary switch cleared;
  9. wait until both power-good acknowledges are low.
- R4: The power-up wait ends only when both power-good acknowledges are high. The power-down wait ends only when both are low. While the two disagree, the block keeps waiting.
- R5: On power-up the SRAM wait ends when every bit of `sram_ack` selected by `SRAM_ACK_MASK` is 0. On power-down it ends when every selected bit is 1. Bits outside the mask are ignored. With a zero mask there is no SRAM wait.
- R6: With `BUS_PROT_MASK` zero, `bus_prot` stays 0 and the two protection steps are left out of the sequences.
- R7: At most one output field changes per clock cycle. Each action step lasts `STEP_HOLD` cycles, so successive changes are at least `STEP_HOLD` cycles apart.
- R8: A wait that lasts `TMO_LIMIT` cycles aborts the sequence. The block then sets `err`, returns `busy` to 0, leaves `done` at 0 and leaves the outputs and `dom_on` where they were.
- R9: A request for the state the domain is already in changes no output, raises `done` in the next cycle and never raises `busy`.
- R10: A request arriving while `busy` is 1 is ignored; the running sequence is neither reversed nor restarted.
- R11: `done` and `err` hold until the next accepted request, which clears both.
- R12: `dom_on` goes to 1 when a power-up completes and to 0 when a power-down completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, accepted only when idle |
| req_on | input | 1 | Requested state: 1 on, 0 off |
| pg_ack_main | input | 1 | Power-good acknowledge of the main switch stage |
| pg_ack_sec | input | 1 | Power-good acknowledge of the secondary switch stage |
| sram_ack | input | SRAM_ACK_W | SRAM power-down acknowledges |
| pwr_ctl | output | 5 | Control word: bit0 reset_n, bit1 isolation, bit2 main, bit3 secondary, bit4 clock disable |
| sram_pdn | output | SRAM_PDN_W | SRAM power-down controls |
| bus_prot | output | BUS_PROT_W | Bus protection, `BUS_PROT_MASK` while raised |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last accepted request completed |
| err | output | 1 | Last sequence aborted by timeout |
| dom_on | output | 1 | Domain state after the last completed sequence |

## Verification
The bench models the power-good acknowledges with unequal delays. A design that accepted a single acknowledge would therefore lift the clock disable while the other was still low. It also drives the SRAM acknowledge bits outside the mask to the wrong polarity, so a design that ignored the mask would hang and time out.

Several further cases are driven:
- An opposite-direction request is issued in the middle of a power-down. A design that accepted it would show power-up events in the recorded change order.
- A power-good acknowledge is held stuck to force a timeout. Recovery must then clear `err` at the moment the next request is accepted.
- A second instance, with both masks zero and a constant SRAM acknowledge, must finish both sequences without touching `bus_prot`. A design that kept the skipped waits would time out instead.

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
  parameter int SRAM_PDN_W = 4,
  parameter int SRAM_ACK_W = 4,
  parameter logic [SRAM_ACK_W-1:0] SRAM_ACK_MASK = 4'b0011,
  parameter int BUS_PROT_W = 2,
  parameter logic [BUS_PROT_W-1:0] BUS_PROT_MASK = 2'b11,
  parameter int STEP_HOLD = 2,
  parameter int TMO_W = 8,
  parameter int TMO_LIMIT = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_on,
  input  logic                  pg_ack_main,
  input  logic                  pg_ack_sec,
  input  logic [SRAM_ACK_W-1:0] sram_ack,
  output logic [4:0]            pwr_ctl,
  output logic [SRAM_PDN_W-1:0] sram_pdn,
  output logic [BUS_PROT_W-1:0] bus_prot,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic                  dom_on
);
  localparam int HOLD_W = $clog2(STEP_HOLD + 1);
  localparam bit USE_SACK = (SRAM_ACK_MASK != '0);
  localparam bit USE_PROT = (BUS_PROT_MASK != '0);
  localparam int C_RSTB = 0, C_ISO = 1, C_MAIN = 2, C_SEC = 3, C_CKDIS = 4;
  localparam logic [4:0] CTL_OFF = 5'b10010;

  typedef enum logic [4:0] {
    S_IDLE,
    U_MAIN, U_SEC, U_PG, U_CLK, U_ISO, U_RST, U_SRAM, U_SACK, U_PROT,
    D_PROT, D_SRAM, D_SACK, D_ISO, D_RST, D_CLK, D_MAIN, D_SEC, D_PG
  } st_t;

  st_t               st, nx;
  logic [HOLD_W-1:0] hold;
  logic [TMO_W-1:0]  tmo;
  logic              prot_up, waiting, cond, adv, start, tmo_hit;

  function automatic st_t follow(st_t s);
    case (s)
      U_MAIN:  return U_SEC;
      U_SEC:   return U_PG;
      U_PG:    return U_CLK;
      U_CLK:   return U_ISO;
      U_ISO:   return U_RST;
      U_RST:   return U_SRAM;
      U_SRAM:  return USE_SACK ? U_SACK : (USE_PROT ? U_PROT : S_IDLE);
      U_SACK:  return USE_PROT ? U_PROT : S_IDLE;
      D_PROT:  return D_SRAM;
      D_SRAM:  return USE_SACK ? D_SACK : D_ISO;
      D_SACK:  return D_ISO;
      D_ISO:   return D_RST;
      D_RST:   return D_CLK;
      D_CLK:   return D_MAIN;
      D_MAIN:  return D_SEC;
      D_SEC:   return D_PG;
      default: return S_IDLE;
    endcase
  endfunction

  always_comb begin
    case (st)
      U_PG:    cond = pg_ack_main & pg_ack_sec;
      D_PG:    cond = !pg_ack_main & !pg_ack_sec;
      U_SACK:  cond = (sram_ack & SRAM_ACK_MASK) == '0;
      D_SACK:  cond = (sram_ack & SRAM_ACK_MASK) == SRAM_ACK_MASK;
      default: cond = 1'b0;
    endcase
  end

  assign busy     = (st != S_IDLE);
  assign waiting  = st inside {U_PG, U_SACK, D_SACK, D_PG};
  assign start    = !busy && req_valid;
  assign adv      = busy && (waiting ? cond : (hold == HOLD_W'(STEP_HOLD - 1)));
  assign tmo_hit  = waiting && !cond && (tmo == TMO_W'(TMO_LIMIT - 1));
  assign nx       = busy ? follow(st) : (req_on ? U_MAIN : (USE_PROT ? D_PROT : D_SRAM));
  assign bus_prot = prot_up ? BUS_PROT_MASK : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      hold     <= '0;
      tmo      <= '0;
      pwr_ctl  <= CTL_OFF;
      sram_pdn <= '1;
      prot_up  <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      dom_on   <= 1'b0;
    end else if (start && (req_on == dom_on)) begin
      done <= 1'b1;
      err  <= 1'b0;
    end else if (start || adv) begin
      if (start) begin
        done <= 1'b0;
        err  <= 1'b0;
      end
      st   <= nx;
      hold <= '0;
      tmo  <= '0;
      if (nx == S_IDLE) begin
        done   <= 1'b1;
        dom_on <= (st != D_PG);
      end
      case (nx)
        U_MAIN:  pwr_ctl[C_MAIN]  <= 1'b1;
        U_SEC:   pwr_ctl[C_SEC]   <= 1'b1;
        U_CLK:   pwr_ctl[C_CKDIS] <= 1'b0;
        U_ISO:   pwr_ctl[C_ISO]   <= 1'b0;
        U_RST:   pwr_ctl[C_RSTB]  <= 1'b1;
        U_SRAM:  sram_pdn         <= '0;
        U_PROT:  prot_up          <= 1'b0;
        D_PROT:  prot_up          <= 1'b1;
        D_SRAM:  sram_pdn         <= '1;
        D_ISO:   pwr_ctl[C_ISO]   <= 1'b1;
        D_RST:   pwr_ctl[C_RSTB]  <= 1'b0;
        D_CLK:   pwr_ctl[C_CKDIS] <= 1'b1;
        D_MAIN:  pwr_ctl[C_MAIN]  <= 1'b0;
        D_SEC:   pwr_ctl[C_SEC]   <= 1'b0;
        default: ;
      endcase
    end else if (tmo_hit) begin
      st  <= S_IDLE;
      err <= 1'b1;
    end else if (busy) begin
      if (waiting) tmo <= tmo + 1'b1;
      else         hold <= hold + 1'b1;
    end
  end

  a_r7_one_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pwr_ctl ^ $past(pwr_ctl), |(sram_pdn ^ $past(sram_pdn)),
                prot_up ^ $past(prot_up)}) <= 1);

  a_r4_pg_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ctl[C_CKDIS]) |-> $past(pg_ack_main && pg_ack_sec));

  a_r2_iso_after_power: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ctl[C_ISO]) |-> (pwr_ctl[C_MAIN] && pwr_ctl[C_SEC] && !pwr_ctl[C_CKDIS]));

  a_r3_switch_off_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ctl[C_MAIN]) |-> (pwr_ctl[C_ISO] && !pwr_ctl[C_RSTB] && pwr_ctl[C_CKDIS]
                                && sram_pdn == '1));

  a_r6_prot_release_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_up) |-> (pwr_ctl[C_RSTB] && sram_pdn == '0));

  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && !done));

  a_r11_accept_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !err);
endmodule

// File: tb/test_pwr_dom_seq.sv
module test_pwr_dom_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n = 1'b0;
  int n_chk = 0, n_err = 0, cyc = 0;

  logic a_rv = 0, a_ro = 0, a_pm, a_ps, a_stick = 0;
  logic [3:0] a_sack, a_pdn;
  logic [4:0] a_ctl;
  logic [1:0] a_prot;
  logic a_busy, a_done, a_err, a_on;
  logic [2:0] sh_m;
  logic [7:0] sh_s, sh_k;

  logic b_rv = 0, b_ro = 0, b_pm, b_ps;
  logic [3:0] b_pdn;
  logic [4:0] b_ctl;
  logic [1:0] b_prot;
  logic b_busy, b_done, b_err, b_on, b_prot_seen = 0;

  pwr_dom_seq i_pwr_dom_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(a_rv), .req_on(a_ro),
    .pg_ack_main(a_pm), .pg_ack_sec(a_ps), .sram_ack(a_sack),
    .pwr_ctl(a_ctl), .sram_pdn(a_pdn), .bus_prot(a_prot),
    .busy(a_busy), .done(a_done), .err(a_err), .dom_on(a_on));

  pwr_dom_seq #(.SRAM_ACK_MASK(4'b0000), .BUS_PROT_MASK(2'b00), .STEP_HOLD(1))
  i_pwr_dom_seq_bare (
    .clk(clk), .rst_n(rst_n), .req_valid(b_rv), .req_on(b_ro),
    .pg_ack_main(b_pm), .pg_ack_sec(b_ps), .sram_ack(4'b1010),
    .pwr_ctl(b_ctl), .sram_pdn(b_pdn), .bus_prot(b_prot),
    .busy(b_busy), .done(b_done), .err(b_err), .dom_on(b_on));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_m <= '0; sh_s <= '0; sh_k <= '1; b_pm <= 1'b0; b_ps <= 1'b0;
    end else begin
      sh_m <= {sh_m[1:0], a_ctl[2]};
      sh_s <= {sh_s[6:0], a_ctl[3] & !a_stick};
      sh_k <= {sh_k[5:0], a_pdn[1:0]};
      b_pm <= b_ctl[2];
      b_ps <= b_ctl[3];
    end
  assign a_pm   = sh_m[2];
  assign a_ps   = sh_s[7];
  assign a_sack = {~a_pdn[3:2], sh_k[7:6]};

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int a_ev[32], a_at[32], a_n = 0, b_ev[32], b_n = 0;
  logic [4:0] pa_ctl, pb_ctl;
  logic [3:0] pa_pdn, pb_pdn;
  logic [1:0] pa_prot;

  task automatic push_a(int c);
    if (a_n < 32) begin a_ev[a_n] = c; a_at[a_n] = cyc; end
    a_n++;
  endtask
  task automatic push_b(int c);
    if (b_n < 32) b_ev[b_n] = c;
    b_n++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (a_ctl[2] && !pa_ctl[2]) push_a(1);
      if (a_ctl[3] && !pa_ctl[3]) push_a(2);
      if (!a_ctl[4] && pa_ctl[4]) begin
        push_a(3);
        chk(a_pm && a_ps, "R4 clock enabled before both power-good", {a_pm, a_ps}, 2'b11);
      end
      if (!a_ctl[1] && pa_ctl[1]) push_a(4);
      if (a_ctl[0] && !pa_ctl[0]) push_a(5);
      if (a_pdn == 0 && pa_pdn != 0) push_a(6);
      if (a_prot == 0 && pa_prot != 0) begin
        push_a(7);
        chk((a_sack & 4'h3) == 0, "R5 protection dropped before SRAM acks low", a_sack & 4'h3, 0);
      end
      if (a_prot != 0 && pa_prot == 0) push_a(11);
      if (a_pdn != 0 && pa_pdn == 0) push_a(12);
      if (a_ctl[1] && !pa_ctl[1]) begin
        push_a(13);
        chk((a_sack & 4'h3) == 4'h3, "R5 isolation set before SRAM acks high", a_sack & 4'h3, 3);
      end
      if (!a_ctl[0] && pa_ctl[0]) push_a(14);
      if (a_ctl[4] && !pa_ctl[4]) push_a(15);
      if (!a_ctl[2] && pa_ctl[2]) push_a(16);
      if (!a_ctl[3] && pa_ctl[3]) push_a(17);
      if (b_ctl[2] && !pb_ctl[2]) push_b(1);
      if (b_ctl[3] && !pb_ctl[3]) push_b(2);
      if (!b_ctl[4] && pb_ctl[4]) push_b(3);
      if (!b_ctl[1] && pb_ctl[1]) push_b(4);
      if (b_ctl[0] && !pb_ctl[0]) push_b(5);
      if (b_pdn == 0 && pb_pdn != 0) push_b(6);
      if (b_pdn != 0 && pb_pdn == 0) push_b(12);
      if (b_ctl[1] && !pb_ctl[1]) push_b(13);
      if (!b_ctl[0] && pb_ctl[0]) push_b(14);
      if (b_ctl[4] && !pb_ctl[4]) push_b(15);
      if (!b_ctl[2] && pb_ctl[2]) push_b(16);
      if (!b_ctl[3] && pb_ctl[3]) push_b(17);
      if (b_prot != 0) b_prot_seen = 1;
    end
    pa_ctl = a_ctl; pa_pdn = a_pdn; pa_prot = a_prot;
    pb_ctl = b_ctl; pb_pdn = b_pdn;
  end

  task automatic cmp_seq(string tag, bit use_b, int exp[7], int n);
    int got = use_b ? b_n : a_n;
    chk(got == n, {tag, " event count"}, got, n);
    for (int k = 0; k < n && k < got; k++) begin
      int v = use_b ? b_ev[k] : a_ev[k];
      chk(v == exp[k], {tag, " event order"}, v, exp[k]);
      if (!use_b && k > 0)
        chk(a_at[k] - a_at[k-1] >= 2, "R7 step shorter than hold", a_at[k] - a_at[k-1], 2);
    end
  endtask

  task automatic req_a(bit on);
    @(negedge clk); a_rv = 1; a_ro = on;
    @(negedge clk); a_rv = 0;
  endtask
  task automatic req_b(bit on);
    @(negedge clk); b_rv = 1; b_ro = on;
    @(negedge clk); b_rv = 0;
  endtask
  task automatic wait_a();
    for (int i = 0; i < 3000 && a_busy; i++) @(negedge clk);
  endtask
  task automatic wait_b();
    for (int i = 0; i < 3000 && b_busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(a_ctl == 5'b10010, "R1 control word", a_ctl, 5'b10010);
    chk(a_pdn == 4'hF, "R1 sram_pdn", a_pdn, 4'hF);
    chk(a_prot == 2'b11, "R1 bus_prot", a_prot, 2'b11);
    chk({a_busy, a_done, a_err, a_on} == 0, "R1 status", {a_busy, a_done, a_err, a_on}, 0);
  endtask

  task automatic t_same(bit on);
    a_n = 0;
    req_a(on);
    chk(a_done && !a_busy, "R9 same-state done", {a_done, a_busy}, 2'b10);
    repeat (3) @(negedge clk);
    chk(a_n == 0 && !a_busy, "R9 same-state no output change", a_n, 0);
  endtask

  task automatic t_on();
    a_n = 0;
    req_a(1);
    chk(a_busy && !a_done, "R2 busy after accept", {a_busy, a_done}, 2'b10);
    wait_a();
    chk(a_on && a_done && !a_err, "R12 on completed", {a_on, a_done, a_err}, 3'b110);
    chk(a_ctl == 5'b01101, "R2 final control word", a_ctl, 5'b01101);
    chk(a_pdn == 0 && a_prot == 0, "R2 final sram/prot", {a_pdn, a_prot}, 0);
    cmp_seq("R2", 0, '{1, 2, 3, 4, 5, 6, 7}, 7);
  endtask

  task automatic t_off_ignore();
    a_n = 0;
    req_a(0);
    repeat (4) @(negedge clk);
    req_a(1);
    repeat (9) @(negedge clk);
    req_a(0);
    wait_a();
    chk(!a_on && a_done && !a_err, "R10 off completed despite requests", {a_on, a_done, a_err}, 3'b010);
    chk(a_ctl == 5'b10010, "R3 final control word", a_ctl, 5'b10010);
    chk(a_pm == 0 && a_ps == 0, "R4 off ends with both acks low", {a_pm, a_ps}, 0);
    cmp_seq("R3 R10", 0, '{11, 12, 13, 14, 15, 16, 17}, 7);
  endtask

  task automatic t_timeout();
    a_stick = 1;
    req_a(1);
    wait_a();
    chk(a_err && !a_done && !a_on, "R8 timeout flags", {a_err, a_done, a_on}, 3'b100);
    chk(a_ctl[3:2] == 2'b11 && a_ctl[4] && a_ctl[1], "R8 outputs frozen", a_ctl, 5'b11110);
    repeat (5) @(negedge clk);
    chk(a_err, "R11 err held", a_err, 1);
    a_stick = 0;
    repeat (12) @(negedge clk);
    req_a(1);
    chk(!a_err && !a_done, "R11 accept clears err", {a_err, a_done}, 0);
    wait_a();
    chk(a_on && a_done && !a_err, "R12 recovery on", {a_on, a_done, a_err}, 3'b110);
  endtask

  task automatic t_bare();
    b_n = 0;
    req_b(1);
    wait_b();
    chk(b_on && !b_err, "R6 bare on completes", {b_on, b_err}, 2'b10);
    cmp_seq("R5 R6 bare on", 1, '{1, 2, 3, 4, 5, 6, 0}, 6);
    b_n = 0;
    req_b(0);
    wait_b();
    chk(!b_on && b_done && !b_err, "R6 bare off completes", {b_on, b_done, b_err}, 3'b010);
    cmp_seq("R5 R6 bare off", 1, '{12, 13, 14, 15, 16, 17, 0}, 6);
    chk(!b_prot_seen, "R6 bus_prot stays zero", b_prot_seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_same(0);
    t_on();
    t_same(1);
    t_off_ignore();
    t_timeout();
    t_bare();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule